// File: doc/BRIEF.md
# Camera-bus interrupt, halt and reset controller

This block gathers completion and error events coming from two I2C masters, each running two command queues, into one 32-bit interrupt status word. Software enables sources through a mask register, clears them through a per-bit clear register or a clear-everything register, and sees a single level interrupt whenever an enabled status bit is set.

Errors reported by a master make the block raise a halt request toward that master's queue engine without waiting for software. Software can raise the same halt by writing a halt command. The engine answers on the event bus, and the block turns that answer into a halt-acknowledge status bit. Software can also write a reset command that selects one master or both. The block holds the matching queue-reset outputs for a fixed number of cycles and then posts a reset-done status bit.

Top module: `irq_halt_hub`

## Requirements
- R1: A one-cycle pulse on `ev_i` bit 0, 4, 8, 12, 16 or 20 sets the same bit of the status word (read at address 0) on the next clock edge. The bit stays set until it is cleared.
- R2: The mask register (address 1) resets to 0. `irq_o` is high exactly while some status bit and the same mask bit are both 1.
- R3: A write to address 2 clears every status bit whose data bit is 1. An event arriving in the same cycle as the clear of its bit leaves that bit set.
- R4: A write to address 3 with data bit 0 set clears the whole status word. A write there with data bit 0 clear changes nothing.
- R5: An event on any bit of 0x18000ee6 raises `halt_req_o[0]` on the next edge, and an event on any bit of 0x60ee6000 raises `halt_req_o[1]`. The four NACK bits 27 to 30 belong to these groups (27 and 28 to master 0, 29 and 30 to master 1) and are recorded in status like the other event bits.
- R6: A write to address 4 with data bit m set raises `halt_req_o[m]` on the next edge.
- R7: While `halt_req_o[m]` is high, a pulse on `ev_i[25+m]` drops the request and sets status bit 25+m on the next edge. When no halt is pending, that input is ignored.
- R8: A write to address 5 of 0x0f73f3f7 selects both masters, 0x000003f1 selects master 0 and 0x0003f001 selects master 1. The selected `q_reset_o` bits are high for the 4 cycles after the write edge, and status bit 24 is set on the 4th edge after it. Any other value is ignored.
- R9: A reset command that selects master m withdraws a pending `halt_req_o[m]`, unless an error event for that master arrives in the same cycle.
- R10: `ev_i` bits 3, 24 and 31 never set a status bit.
- R11: After reset, the status word, mask, `irq_o`, `halt_req_o` and `q_reset_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address (0 status, 1 mask) |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| ev_i | input | 32 | Event pulses from the queue engines, in status bit positions |
| halt_req_o | output | 2 | Halt request per master, held until acknowledged |
| q_reset_o | output | 2 | Queue reset per master |
| irq_o | output | 1 | Level interrupt |

## Verification
Status, halt and interrupt results are due one edge after the event or write that causes them. The queue-reset outputs stay high for the next four edges, and reset-done appears on the fourth edge after the write. Each stimulus pushes its expected results into a scoreboard tagged with the cycle in which they are due. A monitor samples one nanosecond after each rising edge and compares only the entries that are due in that cycle, so results that are delayed by different amounts can overlap without confusing the checks. Ignored inputs are checked by reading the status word and halt outputs after the stimulus.

// File: rtl/irq_halt_hub.sv
module irq_halt_hub #(
  parameter int RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic [31:0] ev_i,
  output logic [1:0]  halt_req_o,
  output logic [1:0]  q_reset_o,
  output logic        irq_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [31:0] EXT_OK  = 32'h78fffff7;
  localparam logic [31:0] ERR_M0  = 32'h18000ee6;
  localparam logic [31:0] ERR_M1  = 32'h60ee6000;
  localparam logic [31:0] RST_ALL = 32'h0f73f3f7;
  localparam logic [31:0] RST_M0  = 32'h000003f1;
  localparam logic [31:0] RST_M1  = 32'h0003f001;
  localparam logic [2:0] A_STAT = 3'd0, A_MASK = 3'd1, A_CLR = 3'd2,
                         A_GCLR = 3'd3, A_HALT = 3'd4, A_RST = 3'd5;

  logic [31:0] st_q, mask_q;
  logic [CW-1:0] cnt_q;
  logic [1:0] rsel_q;

  wire do_mask = wr_en && wr_addr == A_MASK;
  wire do_clr  = wr_en && wr_addr == A_CLR;
  wire do_gclr = wr_en && wr_addr == A_GCLR && wr_data[0];
  wire do_halt = wr_en && wr_addr == A_HALT;
  wire do_rst  = wr_en && wr_addr == A_RST;

  logic [1:0] rst_pick;
  always_comb begin
    rst_pick = 2'b00;
    if (do_rst) begin
      if (wr_data == RST_ALL)     rst_pick = 2'b11;
      else if (wr_data == RST_M0) rst_pick = 2'b01;
      else if (wr_data == RST_M1) rst_pick = 2'b10;
    end
  end

  wire [1:0] err_hit = {|(ev_i & ERR_M1), |(ev_i & ERR_M0)};
  wire [1:0] ack_hit = ev_i[26:25] & halt_req_o;
  wire       done    = cnt_q == CW'(1);

  wire [31:0] set_v = (ev_i & EXT_OK) | {5'd0, ack_hit, done, 24'd0};
  wire [31:0] clr_v = do_gclr ? '1 : (do_clr ? wr_data : '0);
  wire [1:0]  swh   = do_halt ? wr_data[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= '0;
      mask_q     <= '0;
      halt_req_o <= '0;
      cnt_q      <= '0;
      rsel_q     <= '0;
    end else begin
      st_q       <= (st_q & ~clr_v) | set_v;
      if (do_mask) mask_q <= wr_data;
      halt_req_o <= (halt_req_o & ~ack_hit & ~rst_pick) | err_hit | swh;
      if (rst_pick != 2'b00) begin
        cnt_q  <= CW'(RST_CYCLES);
        rsel_q <= ((cnt_q != '0) ? rsel_q : 2'b00) | rst_pick;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CW'(1);
        if (done) rsel_q <= 2'b00;
      end
    end
  end

  assign q_reset_o = rsel_q;
  assign irq_o     = |(st_q & mask_q);
  assign rd_data   = (rd_addr == A_STAT) ? st_q : (rd_addr == A_MASK) ? mask_q : '0;

  assert_halt_err0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev_i & ERR_M0)) |=> halt_req_o[0]);
  assert_halt_err1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev_i & ERR_M1)) |=> halt_req_o[1]);
  assert_ack_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req_o[0] && ev_i[25]) |=> st_q[25]);
  assert_done_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> st_q[24]);
  assert_qreset_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|q_reset_o) |-> $past(do_rst));
  assert_event_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i[0] && do_clr) |=> st_q[0]);
  assert_unused_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !st_q[3] && !st_q[31]);
  assert_irq_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_q != '0));
endmodule

// File: tb/irq_halt_hub_tb.sv
`timescale 1ns/100ps
module irq_halt_hub_tb_top;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, ev_i = 0;
  logic [31:0] rd_data;
  logic [1:0] halt_req_o, q_reset_o;
  logic irq_o;

  irq_halt_hub dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ev_i(ev_i),
    .halt_req_o(halt_req_o), .q_reset_o(q_reset_o), .irq_o(irq_o));

  always #2 clk = ~clk;

  typedef struct { int kind; int due; logic [31:0] val; string req; } item_t;
  item_t sb[$];
  int cyc = 0, checks = 0, fails = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int kind, int dly, logic [31:0] v, string req);
    item_t it;
    it.kind = kind; it.due = cyc + dly; it.val = v; it.req = req;
    sb.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        logic [31:0] got;
        case (sb[i].kind)
          0: got = rd_data;
          1: got = {31'd0, irq_o};
          2: got = {30'd0, halt_req_o};
          default: got = {30'd0, q_reset_o};
        endcase
        checks++;
        if (got !== sb[i].val) begin
          fails++;
          $display("FAIL %s kind %0d cycle %0d: got %h expected %h",
                   sb[i].req, sb[i].kind, cyc, got, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic drive(logic we, logic [2:0] a, logic [31:0] d, logic [31:0] ev, logic [2:0] ra);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; ev_i = ev; rd_addr = ra;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(1);
    expect_at(0, 1, 0, "R11"); expect_at(1, 1, 0, "R11");
    expect_at(2, 1, 0, "R11"); expect_at(3, 1, 0, "R11");
    drive(0, 0, 0, 32'h0001_0001, 0);
    expect_at(0, 1, 32'h0001_0001, "R1"); expect_at(1, 1, 0, "R2");
    drive(1, 1, 32'h1, 0, 1);
    expect_at(0, 1, 32'h1, "R2"); expect_at(1, 1, 1, "R2");
    drive(1, 2, 32'h1, 0, 0);
    expect_at(0, 1, 32'h0001_0000, "R3"); expect_at(1, 1, 0, "R3");
    drive(1, 2, 32'h0001_0010, 32'h10, 0);
    expect_at(0, 1, 32'h10, "R3");
    drive(1, 3, 32'h0, 0, 0);
    expect_at(0, 1, 32'h10, "R4");
    drive(1, 3, 32'h1, 0, 0);
    expect_at(0, 1, 0, "R4");
    drive(0, 0, 0, 32'h8300_0008, 0);
    expect_at(0, 1, 0, "R10"); expect_at(2, 1, 0, "R7");
    drive(0, 0, 0, 32'h0800_0000, 0);
    expect_at(0, 1, 32'h0800_0000, "R5"); expect_at(2, 1, 2'b01, "R5");
    drive(0, 0, 0, 32'h0200_0000, 0);
    expect_at(0, 1, 32'h0A00_0000, "R7"); expect_at(2, 1, 0, "R7");
    drive(1, 3, 32'h1, 0, 0);
    drive(0, 0, 0, 32'h0000_2000, 0);
    expect_at(0, 1, 32'h2000, "R5"); expect_at(2, 1, 2'b10, "R5");
    drive(1, 4, 32'h1, 0, 0);
    expect_at(2, 1, 2'b11, "R6");
    drive(1, 5, 32'h0000_03f1, 0, 0);
    expect_at(2, 1, 2'b10, "R9");
    expect_at(3, 1, 2'b01, "R8"); expect_at(3, 4, 2'b01, "R8");
    expect_at(3, 5, 0, "R8");
    expect_at(0, 4, 32'h2000, "R8"); expect_at(0, 5, 32'h0100_2000, "R8");
    idle(5);
    drive(1, 3, 32'h1, 0, 0);
    drive(1, 5, 32'h1234_5678, 0, 0);
    expect_at(3, 1, 0, "R8"); expect_at(0, 5, 0, "R8");
    idle(5);
    drive(1, 5, 32'h0f73_f3f7, 0, 0);
    expect_at(2, 1, 0, "R9"); expect_at(3, 1, 2'b11, "R8");
    expect_at(0, 5, 32'h0100_0000, "R8");
    idle(5);
    drive(1, 1, 32'h0100_0000, 0, 1);
    expect_at(0, 1, 32'h0100_0000, "R2"); expect_at(1, 1, 1, "R2");
    drive(1, 2, 32'h0100_0000, 0, 0);
    expect_at(0, 1, 0, "R3"); expect_at(1, 1, 0, "R2");
    drive(1, 5, 32'h0003_f001, 32'h2000_0000, 0);
    expect_at(2, 1, 2'b10, "R9"); expect_at(0, 1, 32'h2000_0000, "R5");
    expect_at(3, 1, 2'b10, "R8"); expect_at(0, 5, 32'h2100_0000, "R8");
    idle(5);
    drive(0, 0, 0, 32'h0400_0000, 0);
    expect_at(2, 1, 0, "R7"); expect_at(0, 1, 32'h2500_0000, "R7");
    idle(3);
    if (sb.size() != 0) begin
      fails++; checks++;
      $display("FAIL scoreboard R1 left %0d items, expected 0", sb.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule